// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block sits between the interrupt sources of a serial port and the host-visible interrupt identification register. Each cycle it masks five pending flags (line status, character timeout, received data, transmitter-holding-empty and modem status) with the 4-bit interrupt-enable register. It then reports the single highest-ranked survivor as a 4-bit identification code. It also drives the interrupt request line, which is gated by an output-enable bit taken from the modem control register.

The transmitter-holding-empty source is the only pending flag kept inside the block. A two-state machine holds it. The state `TXE_IDLE` moves to `TXE_PEND` on the transition ARM, and `TXE_PEND` returns to `TXE_IDLE` on the transition ACK. ARM fires when the enable register is written with its transmit bit set while the holding-empty status is high, or when the transmit path signals that the holding register has just become empty. ACK fires when the holding register is written, or when the identification register is read while it shows the transmit-empty code. A holding-register write in the same cycle as an ARM condition keeps the machine in `TXE_IDLE`.

The other four flags are levels owned by the receive path, the line status logic and the modem status logic. The identification code and the request line are combinational in the current inputs and in the registered enable and pending state.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0, the transmit-empty flag is clear, the identification code is 0x1, `int_none` is high and `irq` is low.
- R2: A write to the enable register stores only write-data bits 3:0, and `ier_rd` shows them from the next cycle. Bit 0 enables receive data and timeout, bit 1 enables transmit-empty, bit 2 enables line status and bit 3 enables modem status.
- R3: The codes rank in this order, highest first: line status 0x6, character timeout 0xC, received data 0x4, transmit-empty 0x2, modem status 0x0. Each code appears only when its source is pending and its enable bit is set.
- R4: When no enabled source is pending, the code is 0x1 and `int_none` is high. A pending source whose enable bit is clear has no effect on the code or on `irq`.
- R5: An enable write with data bit 1 set while `thre` is high marks transmit-empty pending from the next cycle. A `thre_set` pulse does the same.
- R6: A `thr_we` pulse clears the transmit-empty flag from the next cycle. It also blocks an ARM condition that arrives in the same cycle.
- R7: An `iir_re` pulse clears the transmit-empty flag only when the code shown in that cycle is 0x2. A read that shows any other code leaves the flag pending.
- R8: `irq` is high exactly when `irq_gate` is high and the code is not 0x1. Dropping `irq_gate` drops `irq` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ier_we | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| thr_we | input | 1 | Transmit holding register write strobe |
| thre | input | 1 | Holding-empty status bit |
| thre_set | input | 1 | Pulse: holding register just became empty |
| iir_re | input | 1 | Identification register read strobe |
| src_lsr | input | 1 | Line status pending |
| src_cto | input | 1 | Character timeout pending |
| src_rda | input | 1 | Received data available pending |
| src_msr | input | 1 | Modem status pending |
| irq_gate | input | 1 | Modem control output-enable bit for the request line |
| iid | output | 4 | Identification code |
| int_none | output | 1 | No enabled interrupt pending |
| irq | output | 1 | Interrupt request |
| ier_rd | output | 4 | Enable register contents |

## Verification
A corrupted enable register shows on `ier_rd` one cycle after the write, and it also shows in the code on the first cycle that a masked source is raised. A transmit-empty flag stuck in the wrong state shows as a 0x2 code that fails to appear, or fails to go away, one cycle after ARM or ACK. This is visible only while no higher source is enabled, so the random phase keeps the higher sources sparse. A wrong ranking or gate shows in the same cycle as the input change.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int IER_W   = 4;
    localparam int IID_W   = 4;
    localparam int NSRC    = 5;

    // enable bit positions
    localparam int EN_RX   = 0;
    localparam int EN_TXE  = 1;
    localparam int EN_LS   = 2;
    localparam int EN_MS   = 3;

    typedef enum logic [IID_W-1:0] {
        IID_MSR  = 4'h0,
        IID_NONE = 4'h1,
        IID_TXE  = 4'h2,
        IID_RDA  = 4'h4,
        IID_LSR  = 4'h6,
        IID_CTO  = 4'hC
    } iid_e;

    typedef enum logic {
        TXE_IDLE = 1'b0,
        TXE_PEND = 1'b1
    } txe_state_e;

    // code of request slot i, slot 0 ranks highest
    function automatic iid_e slot_code(input int i);
        unique case (i)
            0:       slot_code = IID_LSR;
            1:       slot_code = IID_CTO;
            2:       slot_code = IID_RDA;
            3:       slot_code = IID_TXE;
            default: slot_code = IID_MSR;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_enable_reg.sv
module uart_irq_enable_reg
    import uart_irq_pkg::*;
#(
    parameter int WDATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [WDATA_W-1:0] wdata,
    output logic [IER_W-1:0]   q
);
    localparam int HI_W = WDATA_W - IER_W;

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = wdata[WDATA_W-1:IER_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= wdata[IER_W-1:0];
        end
    end
endmodule

// File: rtl/uart_irq_txe_fsm.sv
module uart_irq_txe_fsm
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic ack,
    input  logic hold_wr,
    output logic pend
);
    txe_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TXE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXE_IDLE: if (!hold_wr && arm) state_d = TXE_PEND;
            TXE_PEND: if (hold_wr || ack)  state_d = TXE_IDLE;
            default:  state_d = TXE_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            TXE_PEND: pend = 1'b1;
            default:  pend = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NSRC-1:0]  req,
    output logic [IID_W-1:0] code
);
    logic [NSRC:0]      taken;
    logic [NSRC-1:0]    grant;
    logic [IID_W-1:0]   part [NSRC];

    assign taken[0] = 1'b0;

    for (genvar i = 0; i < NSRC; i++) begin : g_slot
        assign grant[i]   = req[i] & ~taken[i];
        assign taken[i+1] = taken[i] | req[i];
        assign part[i]    = grant[i] ? IID_W'(slot_code(i)) : '0;
    end

    always_comb begin
        code = taken[NSRC] ? '0 : IID_W'(IID_NONE);
        for (int i = 0; i < NSRC; i++) begin
            code = code | part[i];
        end
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int WDATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ier_we,
    input  logic [WDATA_W-1:0] ier_wdata,
    input  logic               thr_we,
    input  logic               thre,
    input  logic               thre_set,
    input  logic               iir_re,
    input  logic               src_lsr,
    input  logic               src_cto,
    input  logic               src_rda,
    input  logic               src_msr,
    input  logic               irq_gate,
    output logic [IID_W-1:0]   iid,
    output logic               int_none,
    output logic               irq,
    output logic [IER_W-1:0]   ier_rd
);
    logic [IER_W-1:0] ier_q;
    logic             txe_pend;
    logic             txe_arm;
    logic             txe_ack;
    logic [NSRC-1:0]  req;

    uart_irq_enable_reg #(.WDATA_W(WDATA_W)) u_ier (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ier_we),
        .wdata (ier_wdata),
        .q     (ier_q)
    );

    assign txe_arm = (ier_we && ier_wdata[EN_TXE] && thre) || thre_set;
    assign txe_ack = iir_re && (iid == IID_W'(IID_TXE));

    uart_irq_txe_fsm u_txe (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (txe_arm),
        .ack     (txe_ack),
        .hold_wr (thr_we),
        .pend    (txe_pend)
    );

    // slot order = priority order
    assign req[0] = src_lsr  & ier_q[EN_LS];
    assign req[1] = src_cto  & ier_q[EN_RX];
    assign req[2] = src_rda  & ier_q[EN_RX];
    assign req[3] = txe_pend & ier_q[EN_TXE];
    assign req[4] = src_msr  & ier_q[EN_MS];

    uart_irq_prio u_prio (
        .req  (req),
        .code (iid)
    );

    assign int_none = (iid == IID_W'(IID_NONE));
    assign irq      = irq_gate & (|req);
    assign ier_rd   = ier_q;
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk
    import uart_irq_pkg::*;
#(
    parameter int WDATA_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ier_we,
    input logic [WDATA_W-1:0] ier_wdata,
    input logic               thr_we,
    input logic               thre,
    input logic               iir_re,
    input logic               src_lsr,
    input logic               src_cto,
    input logic               irq_gate,
    input logic [IID_W-1:0]   iid,
    input logic               int_none,
    input logic               irq,
    input logic [IER_W-1:0]   ier_rd,
    input logic               txe_pend
);
    p_lsr_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_rd[EN_LS] && src_lsr) |-> (iid == 4'h6));

    p_cto_over_rda_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_rd[EN_RX] && src_cto && !(ier_rd[EN_LS] && src_lsr)) |-> (iid == 4'hC));

    p_none_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int_none |-> !irq);

    p_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_we && ier_wdata[EN_TXE] && thre && !thr_we && !(iir_re && iid == 4'h2))
        |=> txe_pend);

    p_thr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        thr_we |=> (!txe_pend && iid != 4'h2));

    p_read_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_re && iid == 4'h2) |=> !txe_pend);

    p_read_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_re && iid != 4'h2 && txe_pend && !thr_we) |=> txe_pend);

    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_gate |-> !irq);

    p_ier_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ier_we |=> (ier_rd == $past(ier_wdata[IER_W-1:0])));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.WDATA_W(WDATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ier_we    (ier_we),
    .ier_wdata (ier_wdata),
    .thr_we    (thr_we),
    .thre      (thre),
    .iir_re    (iir_re),
    .src_lsr   (src_lsr),
    .src_cto   (src_cto),
    .irq_gate  (irq_gate),
    .iid       (iid),
    .int_none  (int_none),
    .irq       (irq),
    .ier_rd    (ier_rd),
    .txe_pend  (txe_pend)
);

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ier_we = 1'b0;
    logic [7:0] ier_wdata = '0;
    logic       thr_we = 1'b0, thre = 1'b0, thre_set = 1'b0, iir_re = 1'b0;
    logic       src_lsr = 1'b0, src_cto = 1'b0, src_rda = 1'b0, src_msr = 1'b0;
    logic       irq_gate = 1'b0;
    logic [3:0] iid;
    logic       int_none, irq;
    logic [3:0] ier_rd;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [3:0] m_ier = '0;
    logic       m_txp = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    uart_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ier_we(ier_we), .ier_wdata(ier_wdata),
        .thr_we(thr_we), .thre(thre), .thre_set(thre_set), .iir_re(iir_re),
        .src_lsr(src_lsr), .src_cto(src_cto), .src_rda(src_rda), .src_msr(src_msr),
        .irq_gate(irq_gate), .iid(iid), .int_none(int_none), .irq(irq), .ier_rd(ier_rd)
    );

    function automatic logic [3:0] f_iid(logic [3:0] en, logic ls, logic ct,
                                         logic rd, logic tx, logic ms);
        if (en[2] && ls)      return 4'h6;
        else if (en[0] && ct) return 4'hC;
        else if (en[0] && rd) return 4'h4;
        else if (en[1] && tx) return 4'h2;
        else if (en[3] && ms) return 4'h0;
        else                  return 4'h1;
    endfunction

    // reference model, updated on the same edge as the design
    always @(posedge clk) begin
        logic [3:0] cur;
        if (!rst_n) begin
            m_ier = '0;
            m_txp = 1'b0;
        end else begin
            cur = f_iid(m_ier, src_lsr, src_cto, src_rda, m_txp, src_msr);
            if (m_txp) begin
                if (thr_we || (iir_re && cur == 4'h2)) m_txp = 1'b0;
            end else if (!thr_we && ((ier_we && ier_wdata[1] && thre) || thre_set)) begin
                m_txp = 1'b1;
            end
            if (ier_we) m_ier = ier_wdata[3:0];
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [3:0] e;
        e = f_iid(m_ier, src_lsr, src_cto, src_rda, m_txp, src_msr);
        chk(iid == e, {tag, " iid"}, iid, e);
        chk(int_none == (e == 4'h1), {tag, " int_none"}, int_none, e == 4'h1);
        chk(irq == (irq_gate && e != 4'h1), {tag, " irq"}, irq, irq_gate && e != 4'h1);
        chk(ier_rd == m_ier, {tag, " ier"}, ier_rd, m_ier);
    endtask

    task automatic tick(input string tag);
        @(negedge clk);
        check_all(tag);
        @(posedge clk);
        #1;
    endtask

    task automatic clear_pulses();
        ier_we = 1'b0; thr_we = 1'b0; thre_set = 1'b0; iir_re = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(iid == 4'h1 && int_none && !irq && ier_rd == 4'h0, "R1 reset", {iid, ier_rd}, 8'h10);
        rst_n = 1'b1;
        tick("R1");

        // R2 only low bits kept
        ier_we = 1'b1; ier_wdata = 8'hFF; irq_gate = 1'b1;
        tick("R2");
        clear_pulses();
        chk(ier_rd == 4'hF, "R2 ier low bits", ier_rd, 4'hF);

        // R3 priority walk
        src_lsr = 1; src_cto = 1; src_rda = 1; src_msr = 1;
        #1 chk(iid == 4'h6, "R3 lsr", iid, 6);
        tick("R3");
        src_lsr = 0; #1 chk(iid == 4'hC, "R3 cto", iid, 'hC);
        src_cto = 0; #1 chk(iid == 4'h4, "R3 rda", iid, 4);
        src_rda = 0; #1 chk(iid == 4'h0, "R3 msr", iid, 0);
        tick("R3");

        // R5 arm via enable write, R7 clear via read
        ier_we = 1'b1; ier_wdata = 8'h02; thre = 1'b1;
        tick("R5");
        clear_pulses();
        chk(iid == 4'h2 && irq, "R5 arm by write", iid, 2);
        iir_re = 1'b1;
        tick("R7");
        clear_pulses();
        chk(iid == 4'h1 && !irq, "R7 read clears", iid, 1);

        // R5 arm by event, R6 clear by holding write
        thre_set = 1'b1;
        tick("R5");
        clear_pulses();
        chk(iid == 4'h2, "R5 arm by event", iid, 2);
        thr_we = 1'b1;
        tick("R6");
        clear_pulses();
        chk(iid == 4'h1, "R6 thr clears", iid, 1);

        // R6 holding write blocks simultaneous arm
        ier_we = 1'b1; ier_wdata = 8'h06; thr_we = 1'b1;
        tick("R6");
        clear_pulses();
        chk(iid == 4'h1, "R6 write beats arm", iid, 1);

        // R7 read showing another code keeps flag
        thre_set = 1'b1; src_lsr = 1'b1;
        tick("R7");
        clear_pulses();
        iir_re = 1'b1;
        tick("R7");
        clear_pulses();
        src_lsr = 1'b0;
        #1 chk(iid == 4'h2, "R7 read of other code keeps", iid, 2);

        // R8 gate
        irq_gate = 1'b0;
        #1 chk(!irq, "R8 gate low", irq, 0);
        irq_gate = 1'b1;
        #1 chk(irq, "R8 gate high", irq, 1);

        // R4 disabled sources ignored
        ier_we = 1'b1; ier_wdata = 8'hF0;
        tick("R4");
        clear_pulses();
        src_lsr = 1; src_cto = 1; src_rda = 1; src_msr = 1;
        #1 chk(iid == 4'h1 && int_none && !irq, "R4 all masked", iid, 1);
        tick("R4");

        // random phase, R3 R4 R5 R6 R7 R8
        for (int n = 0; n < 3000; n++) begin
            ier_we    = ($urandom % 8) == 0;
            ier_wdata = 8'($urandom);
            thr_we    = ($urandom % 10) == 0;
            thre      = ($urandom % 2) == 0;
            thre_set  = ($urandom % 12) == 0;
            iir_re    = ($urandom % 4) == 0;
            src_lsr   = ($urandom % 9) == 0;
            src_cto   = ($urandom % 9) == 0;
            src_rda   = ($urandom % 6) == 0;
            src_msr   = ($urandom % 3) == 0;
            irq_gate  = ($urandom % 5) != 0;
            tick("R3 R4 R5 R6 R7 R8 random");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule